// File: doc/BRIEF.md
# Sequential Floating-Point Mantissa Multiplier

This block multiplies two floating-point operands that have already been unpacked. Each operand carries a sign, a class code, a signed exponent and a wide fixed-point mantissa. The mantissa is built from several 32-bit words. Its leading one sits at bit `LEAD_POS`, and the low `GUARD_W` bits serve as guard and round positions. A combinational front end first moves the operand of higher class into the second slot. It then resolves every result that involves zero, infinity or NaN, and such a result is returned one cycle after the start cycle.

When both operands are ordinary numbers, a shift-and-add engine builds the product. Each clock it consumes one bit of the multiplier. On each step it shifts the accumulator right, gathers the dropped bits into a sticky flag, and adds the multiplicand when the multiplier bit is one. A multiplier word that is entirely zero costs a single cycle, because the engine moves the accumulator down by a whole word. The guard positions of the multiplier are never stepped. The run ends as soon as no set bit remains above the current position in the top word. A final cycle adds the exponents, XORs the signs and renormalizes by at most one place.

Rounding and repacking are left to the stages downstream. A start/busy/done handshake frames each operation.

Top module: `fmul_seq_unit`

## Requirements
- R1: After reset, `busy`, `done` and every result output are zero.
- R2: Class codes are zero=0, number=1, infinity=2, quiet NaN=3, signalling NaN=4. An operand with a strictly larger code is taken as the second operand. On equal codes, `b` stays second, so with two numbers `a` is the multiplicand and `b` is the multiplier.
- R3: When the second operand is a NaN, the result keeps its class, exponent and mantissa, and takes as sign the XOR of both signs. Sticky is 0.
- R4: Infinity times zero gives the default NaN: class 3, sign 0, exponent 0, only mantissa bit `LEAD_POS` set, sticky 0. Infinity times a number or an infinity returns the infinity operand, with the XOR of both signs.
- R5: Zero times zero or a number returns the zero operand that sits first after ordering. Its exponent and mantissa are kept, the sign is the XOR of both signs and sticky is 0.
- R6: A special-class result has `done` high in the cycle right after the cycle in which `start` was accepted.
- R7: For two numbers, let P be the multiplicand mantissa times the multiplier mantissa with its low `GUARD_W` bits cleared. The mantissa is P shifted right by `LEAD_POS`, and sticky is set when any of the discarded low bits of P is nonzero. The exponent is the sum of the exponents modulo 2^`EXP_W`, and the sign is the XOR of the signs.
- R8: If the mantissa from R7 has any bit above `LEAD_POS` set, it is shifted right once. The bit shifted out is ORed into sticky, and the exponent is incremented.
- R9: A number product raises `done` S+2 cycles after the start cycle. S is the sum of per-word costs. The lowest word costs 1 if its non-guard bits are zero, and 32-`GUARD_W` otherwise. Each middle word costs 1 if zero and 32 otherwise. The top word costs one more than the index of its highest set bit.
- R10: Bits set in the multiplier's guard positions change neither the result nor the latency.
- R11: `busy` is high from the cycle after an accepted start until the result cycle. A `start` seen while `busy` is ignored. `done` lasts one cycle, and the result outputs hold their value until the next `done`.
- R12: A `start` in the cycle where `done` is high is accepted, and both results are delivered in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Accept the operands on this cycle when idle |
| a_sign | input | 1 | Sign of operand a |
| a_cls | input | 3 | Class code of operand a |
| a_exp | input | EXP_W | Exponent of operand a (two's complement) |
| a_mant | input | WORD_W*NWORDS | Mantissa of operand a |
| b_sign | input | 1 | Sign of operand b |
| b_cls | input | 3 | Class code of operand b |
| b_exp | input | EXP_W | Exponent of operand b |
| b_mant | input | WORD_W*NWORDS | Mantissa of operand b |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: result outputs just updated |
| res_sign | output | 1 | Result sign |
| res_cls | output | 3 | Result class code |
| res_exp | output | EXP_W | Result exponent |
| res_mant | output | WORD_W*NWORDS | Result mantissa |
| res_sticky | output | 1 | Result sticky bit |

## Verification
Two events can fall in the same cycle: the completion pulse of one operation and the acceptance of the next `start`. The driver waits for `busy` to drop and issues the next operands at once, so every new operation is started in the `done` cycle of the one before. Special results arrive one cycle apart, so their `done` and the next `start` overlap over and over. The scoreboard judges each pair on two things: the order in which results come out, with every field compared, and the measured latency of each result against the expected latency computed from the operand words.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

  typedef enum logic [2:0] {
    FC_ZERO = 3'd0,
    FC_NUM  = 3'd1,
    FC_INF  = 3'd2,
    FC_QNAN = 3'd3,
    FC_SNAN = 3'd4
  } fcls_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } fmul_state_e;

  function automatic logic cls_is_nan(input logic [2:0] c);
    return (c == FC_QNAN) || (c == FC_SNAN);
  endfunction

endpackage

// File: rtl/fmul_rst_sync.sv
module fmul_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/fmul_order_special.sv
module fmul_order_special
  import fmul_pkg::*;
#(
  parameter int EXP_W    = 16,
  parameter int MANT_W   = 128,
  parameter int LEAD_POS = 114
) (
  input  logic              a_sign,
  input  logic [2:0]        a_cls,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic [MANT_W-1:0] a_mant,
  input  logic              b_sign,
  input  logic [2:0]        b_cls,
  input  logic [EXP_W-1:0]  b_exp,
  input  logic [MANT_W-1:0] b_mant,
  output logic              prod_sign,
  output logic [EXP_W-1:0]  exp_sum,
  output logic [MANT_W-1:0] mcand,
  output logic [MANT_W-1:0] mplier,
  output logic              is_special,
  output logic              s_sign,
  output logic [2:0]        s_cls,
  output logic [EXP_W-1:0]  s_exp,
  output logic [MANT_W-1:0] s_mant
);

  localparam logic [MANT_W-1:0] DNAN_MANT = MANT_W'(1) << LEAD_POS;

  logic              swap;
  logic [2:0]        x_cls,  y_cls;
  logic [EXP_W-1:0]  x_exp,  y_exp;
  logic [MANT_W-1:0] x_mant, y_mant;

  // heavier class goes to the second slot; ties leave b there
  assign swap = a_cls > b_cls;

  always_comb begin
    if (swap) begin
      x_cls = b_cls; x_exp = b_exp; x_mant = b_mant;
      y_cls = a_cls; y_exp = a_exp; y_mant = a_mant;
    end else begin
      x_cls = a_cls; x_exp = a_exp; x_mant = a_mant;
      y_cls = b_cls; y_exp = b_exp; y_mant = b_mant;
    end
  end

  assign prod_sign = a_sign ^ b_sign;
  assign exp_sum   = a_exp + b_exp;
  assign mcand     = x_mant;
  assign mplier    = y_mant;

  always_comb begin
    is_special = 1'b1;
    s_sign     = prod_sign;
    s_cls      = y_cls;
    s_exp      = y_exp;
    s_mant     = y_mant;
    if (cls_is_nan(y_cls)) begin
      s_cls = y_cls;
    end else if (y_cls == FC_INF) begin
      if (x_cls == FC_ZERO) begin
        s_sign = 1'b0;
        s_cls  = FC_QNAN;
        s_exp  = '0;
        s_mant = DNAN_MANT;
      end
    end else if (x_cls == FC_ZERO) begin
      s_cls  = FC_ZERO;
      s_exp  = x_exp;
      s_mant = x_mant;
    end else begin
      is_special = 1'b0;
    end
  end

endmodule

// File: rtl/fmul_mant_seq.sv
module fmul_mant_seq #(
  parameter int WORD_W  = 32,
  parameter int NWORDS  = 4,
  parameter int GUARD_W = 2,
  localparam int MANT_W = WORD_W * NWORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MANT_W-1:0] mcand,
  input  logic [MANT_W-1:0] mplier,
  output logic [MANT_W-1:0] acc,
  output logic              sticky,
  output logic              last_step
);

  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int BIT_W = $clog2(WORD_W);
  localparam int TOP   = NWORDS - 1;
  localparam logic [MANT_W-1:0] GUARD_MASK = (MANT_W'(1) << GUARD_W) - MANT_W'(1);

  logic [MANT_W-1:0] acc_q,  acc_d;
  logic [MANT_W-1:0] x_q,    x_d;
  logic [MANT_W-1:0] y_q,    y_d;
  logic              stk_q,  stk_d;
  logic [IDX_W-1:0]  widx_q, widx_d;
  logic [BIT_W-1:0]  bidx_q, bidx_d;
  logic              act_q,  act_d;
  logic              adv_en;

  logic [WORD_W-1:0] cur_word;
  logic              at_top, word_zero, acc_nz;
  logic [BIT_W:0]    sh_amt;
  logic [WORD_W:0]   above;
  logic [MANT_W-1:0] step_sum;

  assign cur_word  = y_q[widx_q*WORD_W +: WORD_W];
  assign at_top    = (widx_q == IDX_W'(TOP));
  assign word_zero = (cur_word == '0);
  assign acc_nz    = |acc_q;
  assign sh_amt    = (BIT_W+1)'(bidx_q) + (BIT_W+1)'(1);
  assign above     = {1'b0, cur_word} >> sh_amt;
  assign step_sum  = {1'b0, acc_q[MANT_W-1:1]} + (cur_word[bidx_q] ? x_q : '0);
  assign last_step = act_q && at_top && (above == '0);
  assign adv_en    = load || act_q;

  always_comb begin
    acc_d  = acc_q;
    x_d    = x_q;
    y_d    = y_q;
    stk_d  = stk_q;
    widx_d = widx_q;
    bidx_d = bidx_q;
    act_d  = act_q;
    if (load) begin
      acc_d  = '0;
      stk_d  = 1'b0;
      x_d    = mcand;
      y_d    = mplier & ~GUARD_MASK;
      widx_d = '0;
      bidx_d = BIT_W'(GUARD_W);
      act_d  = 1'b1;
    end else if (act_q) begin
      if (!at_top && word_zero) begin
        // whole-word move; nothing to move while the accumulator is empty
        if (acc_nz) begin
          stk_d = stk_q | (|acc_q[WORD_W-1:0]);
          acc_d = acc_q >> WORD_W;
        end
        widx_d = widx_q + IDX_W'(1);
        bidx_d = '0;
      end else begin
        stk_d = stk_q | acc_q[0];
        acc_d = step_sum;
        if (last_step) begin
          act_d = 1'b0;
        end else if (bidx_q == BIT_W'(WORD_W-1)) begin
          widx_d = widx_q + IDX_W'(1);
          bidx_d = '0;
        end else begin
          bidx_d = bidx_q + BIT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      x_q    <= '0;
      y_q    <= '0;
      stk_q  <= 1'b0;
      widx_q <= '0;
      bidx_q <= '0;
      act_q  <= 1'b0;
    end else if (adv_en) begin
      acc_q  <= acc_d;
      x_q    <= x_d;
      y_q    <= y_d;
      stk_q  <= stk_d;
      widx_q <= widx_d;
      bidx_q <= bidx_d;
      act_q  <= act_d;
    end
  end

  assign acc    = acc_q;
  assign sticky = stk_q;

endmodule

// File: rtl/fmul_norm.sv
module fmul_norm #(
  parameter int EXP_W    = 16,
  parameter int MANT_W   = 128,
  parameter int LEAD_POS = 114
) (
  input  logic [MANT_W-1:0] acc,
  input  logic              sticky_in,
  input  logic [EXP_W-1:0]  exp_in,
  output logic [MANT_W-1:0] mant_out,
  output logic              sticky_out,
  output logic [EXP_W-1:0]  exp_out
);

  logic over_two;

  assign over_two = |acc[MANT_W-1:LEAD_POS+1];

  always_comb begin
    if (over_two) begin
      mant_out   = {1'b0, acc[MANT_W-1:1]};
      sticky_out = sticky_in | acc[0];
      exp_out    = exp_in + EXP_W'(1);
    end else begin
      mant_out   = acc;
      sticky_out = sticky_in;
      exp_out    = exp_in;
    end
  end

endmodule

// File: rtl/fmul_seq_unit.sv
module fmul_seq_unit
  import fmul_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int NWORDS   = 4,
  parameter int GUARD_W  = 2,
  parameter int EXP_W    = 16,
  parameter int LEAD_POS = WORD_W * NWORDS - 14,
  localparam int MANT_W  = WORD_W * NWORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              a_sign,
  input  logic [2:0]        a_cls,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic [MANT_W-1:0] a_mant,
  input  logic              b_sign,
  input  logic [2:0]        b_cls,
  input  logic [EXP_W-1:0]  b_exp,
  input  logic [MANT_W-1:0] b_mant,
  output logic              busy,
  output logic              done,
  output logic              res_sign,
  output logic [2:0]        res_cls,
  output logic [EXP_W-1:0]  res_exp,
  output logic [MANT_W-1:0] res_mant,
  output logic              res_sticky
);

  logic rst_i_n;

  fmul_rst_sync rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  logic              prod_sign, is_special, s_sign;
  logic [EXP_W-1:0]  exp_sum, s_exp;
  logic [MANT_W-1:0] mcand, mplier, s_mant;
  logic [2:0]        s_cls;

  fmul_order_special #(
    .EXP_W    (EXP_W),
    .MANT_W   (MANT_W),
    .LEAD_POS (LEAD_POS)
  ) order_i (
    .a_sign     (a_sign),
    .a_cls      (a_cls),
    .a_exp      (a_exp),
    .a_mant     (a_mant),
    .b_sign     (b_sign),
    .b_cls      (b_cls),
    .b_exp      (b_exp),
    .b_mant     (b_mant),
    .prod_sign  (prod_sign),
    .exp_sum    (exp_sum),
    .mcand      (mcand),
    .mplier     (mplier),
    .is_special (is_special),
    .s_sign     (s_sign),
    .s_cls      (s_cls),
    .s_exp      (s_exp),
    .s_mant     (s_mant)
  );

  fmul_state_e st_q, st_d;
  logic        accept, eng_load, last_step;
  logic [MANT_W-1:0] acc;
  logic        acc_sticky;

  assign accept   = start && (st_q == ST_IDLE);
  assign eng_load = accept && !is_special;

  fmul_mant_seq #(
    .WORD_W  (WORD_W),
    .NWORDS  (NWORDS),
    .GUARD_W (GUARD_W)
  ) engine_i (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .load      (eng_load),
    .mcand     (mcand),
    .mplier    (mplier),
    .acc       (acc),
    .sticky    (acc_sticky),
    .last_step (last_step)
  );

  logic             psign_q;
  logic [EXP_W-1:0] pexp_q;

  logic [MANT_W-1:0] n_mant;
  logic              n_sticky;
  logic [EXP_W-1:0]  n_exp;

  fmul_norm #(
    .EXP_W    (EXP_W),
    .MANT_W   (MANT_W),
    .LEAD_POS (LEAD_POS)
  ) norm_i (
    .acc        (acc),
    .sticky_in  (acc_sticky),
    .exp_in     (pexp_q),
    .mant_out   (n_mant),
    .sticky_out (n_sticky),
    .exp_out    (n_exp)
  );

  // next state
  logic res_we, done_d;
  logic              r_sign_d, r_stk_d;
  logic [2:0]        r_cls_d;
  logic [EXP_W-1:0]  r_exp_d;
  logic [MANT_W-1:0] r_mant_d;

  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    res_we = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (is_special) begin
            res_we = 1'b1;
            done_d = 1'b1;
          end else begin
            st_d = ST_RUN;
          end
        end
      end
      ST_RUN:  if (last_step) st_d = ST_FIN;
      ST_FIN: begin
        st_d   = ST_IDLE;
        res_we = 1'b1;
        done_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (st_q == ST_FIN) begin
      r_sign_d = psign_q;
      r_cls_d  = FC_NUM;
      r_exp_d  = n_exp;
      r_mant_d = n_mant;
      r_stk_d  = n_sticky;
    end else begin
      r_sign_d = s_sign;
      r_cls_d  = s_cls;
      r_exp_d  = s_exp;
      r_mant_d = s_mant;
      r_stk_d  = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q <= ST_IDLE;
      done <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      psign_q <= 1'b0;
      pexp_q  <= '0;
    end else if (eng_load) begin
      psign_q <= prod_sign;
      pexp_q  <= exp_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      res_sign   <= 1'b0;
      res_cls    <= '0;
      res_exp    <= '0;
      res_mant   <= '0;
      res_sticky <= 1'b0;
    end else if (res_we) begin
      res_sign   <= r_sign_d;
      res_cls    <= r_cls_d;
      res_exp    <= r_exp_d;
      res_mant   <= r_mant_d;
      res_sticky <= r_stk_d;
    end
  end

  assign busy = (st_q != ST_IDLE);

endmodule

// File: rtl/fmul_seq_unit_chk.sv
module fmul_seq_unit_chk #(
  parameter int EXP_W  = 16,
  parameter int MANT_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [2:0]        res_cls,
  input logic [EXP_W-1:0]  res_exp,
  input logic [MANT_W-1:0] res_mant,
  input logic              res_sticky,
  input logic              res_sign
);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done);

  // R11
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R6
  start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy || done);

  // R3
  special_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && (res_cls != 3'd1) |-> !res_sticky);

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(res_mant) && $stable(res_exp) && $stable(res_cls)
              && $stable(res_sign) && $stable(res_sticky));

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind fmul_seq_unit fmul_seq_unit_chk #(
  .EXP_W  (EXP_W),
  .MANT_W (MANT_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .res_cls    (res_cls),
  .res_exp    (res_exp),
  .res_mant   (res_mant),
  .res_sticky (res_sticky),
  .res_sign   (res_sign)
);

// File: tb/fmul_seq_unit_tb_top.sv
module fmul_seq_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_W   = 32;
  localparam int NWORDS   = 4;
  localparam int GUARD_W  = 2;
  localparam int EXP_W    = 16;
  localparam int MANT_W   = WORD_W * NWORDS;
  localparam int LEAD_POS = MANT_W - 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic              a_sign = 1'b0, b_sign = 1'b0;
  logic [2:0]        a_cls = '0, b_cls = '0;
  logic [EXP_W-1:0]  a_exp = '0, b_exp = '0;
  logic [MANT_W-1:0] a_mant = '0, b_mant = '0;
  logic              busy, done, res_sign, res_sticky;
  logic [2:0]        res_cls;
  logic [EXP_W-1:0]  res_exp;
  logic [MANT_W-1:0] res_mant;

  fmul_seq_unit #(
    .WORD_W(WORD_W), .NWORDS(NWORDS), .GUARD_W(GUARD_W),
    .EXP_W(EXP_W), .LEAD_POS(LEAD_POS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .a_sign(a_sign), .a_cls(a_cls), .a_exp(a_exp), .a_mant(a_mant),
    .b_sign(b_sign), .b_cls(b_cls), .b_exp(b_exp), .b_mant(b_mant),
    .busy(busy), .done(done), .res_sign(res_sign), .res_cls(res_cls),
    .res_exp(res_exp), .res_mant(res_mant), .res_sticky(res_sticky)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic              s;
    logic [2:0]        c;
    logic [EXP_W-1:0]  e;
    logic [MANT_W-1:0] m;
    logic              k;
    int                lat;
    int                t0;
    string             req;
  } exp_t;

  exp_t sbq[$];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic logic [MANT_W-1:0] mk_mant(input int seed);
    logic [31:0] v;
    logic [MANT_W-1:0] m;
    v = seed;
    for (int w = 0; w < NWORDS; w++) begin
      v = v * 32'd1664525 + 32'd1013904223;
      m[w*WORD_W +: WORD_W] = v;
    end
    m = m & ((MANT_W'(1) << (LEAD_POS + 1)) - MANT_W'(1));
    m[LEAD_POS] = 1'b1;
    return m;
  endfunction

  function automatic int lat_of(input logic [MANT_W-1:0] y);
    int s, hi;
    logic [WORD_W-1:0] t;
    s = (y[WORD_W-1:0] == '0) ? 1 : (WORD_W - GUARD_W);
    for (int w = 1; w < NWORDS - 1; w++)
      s += (y[w*WORD_W +: WORD_W] == '0) ? 1 : WORD_W;
    t = y[MANT_W-1 -: WORD_W];
    hi = 1;
    for (int i = 0; i < WORD_W; i++) if (t[i]) hi = i + 1;
    return s + hi + 2;
  endfunction

  function automatic exp_t model(
    input logic as, input logic [2:0] ac, input logic [EXP_W-1:0] ae, input logic [MANT_W-1:0] am,
    input logic bs, input logic [2:0] bc, input logic [EXP_W-1:0] be, input logic [MANT_W-1:0] bm);
    exp_t r;
    logic [2:0] xc, yc;
    logic [EXP_W-1:0] xe, ye;
    logic [MANT_W-1:0] xm, ym, yg, acc;
    logic [2*MANT_W-1:0] p;
    logic sx, st;
    sx = as ^ bs;
    if (ac > bc) begin xc = bc; xe = be; xm = bm; yc = ac; ye = ae; ym = am; end
    else         begin xc = ac; xe = ae; xm = am; yc = bc; ye = be; ym = bm; end
    r.lat = 1; r.k = 1'b0; r.s = sx;
    if (yc == 3'd3 || yc == 3'd4) begin
      r.c = yc; r.e = ye; r.m = ym;
    end else if (yc == 3'd2) begin
      if (xc == 3'd0) begin
        r.s = 1'b0; r.c = 3'd3; r.e = '0; r.m = MANT_W'(1) << LEAD_POS;
      end else begin
        r.c = 3'd2; r.e = ye; r.m = ym;
      end
    end else if (xc == 3'd0) begin
      r.c = 3'd0; r.e = xe; r.m = xm;
    end else begin
      yg = ym & ~((MANT_W'(1) << GUARD_W) - MANT_W'(1));
      p = {{MANT_W{1'b0}}, xm} * {{MANT_W{1'b0}}, yg};
      acc = MANT_W'(p >> LEAD_POS);
      st = |(p & ((2*MANT_W)'(1) << LEAD_POS) - (2*MANT_W)'(1));
      r.e = ae + be;
      if ((acc >> (LEAD_POS + 1)) != '0) begin
        st = st | acc[0];
        acc = acc >> 1;
        r.e = r.e + EXP_W'(1);
      end
      r.c = 3'd1; r.m = acc; r.k = st;
      r.lat = lat_of(yg);
    end
    return r;
  endfunction

  // driver: waits for idle, applies operands, pushes the expected item
  task automatic issue(
    input logic as, input logic [2:0] ac, input logic [EXP_W-1:0] ae, input logic [MANT_W-1:0] am,
    input logic bs, input logic [2:0] bc, input logic [EXP_W-1:0] be, input logic [MANT_W-1:0] bm,
    input string req);
    exp_t it;
    while (busy) @(negedge clk);
    a_sign = as; a_cls = ac; a_exp = ae; a_mant = am;
    b_sign = bs; b_cls = bc; b_exp = be; b_mant = bm;
    start = 1'b1;
    it = model(as, ac, ae, am, bs, bc, be, bm);
    it.t0 = cyc;
    it.req = req;
    sbq.push_back(it);
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor: pops and compares on every done
  always @(negedge clk) begin
    if (rst_n && done && !finished) begin
      if (sbq.size() == 0) begin
        chk(1'b0, $sformatf("R11 unexpected done: got cls=%0d mant=%h, expected no result", res_cls, res_mant));
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(res_sign == e.s && res_cls == e.c && res_exp == e.e && res_mant == e.m && res_sticky == e.k,
            $sformatf("%s result: got s=%0b c=%0d e=%h m=%h k=%0b, expected s=%0b c=%0d e=%h m=%h k=%0b",
                      e.req, res_sign, res_cls, res_exp, res_mant, res_sticky,
                      e.s, e.c, e.e, e.m, e.k));
        chk((cyc - e.t0) == e.lat,
            $sformatf("%s latency: got %0d, expected %0d", e.req, cyc - e.t0, e.lat));
      end
    end
  end

  task automatic summary;
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired: got hang, expected completion");
    summary();
  end

  localparam logic [MANT_W-1:0] ONE  = MANT_W'(1) << LEAD_POS;
  localparam logic [MANT_W-1:0] ALL1 = (MANT_W'(1) << (LEAD_POS + 1)) - MANT_W'(1);

  initial begin
    logic [MANT_W-1:0] ma, mb, mc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, $sformatf("R1 busy: got %0b expected 0", busy));
    chk(done == 1'b0, $sformatf("R1 done: got %0b expected 0", done));
    chk(res_cls == 3'd0 && res_sign == 1'b0, $sformatf("R1 cls/sign: got %0d/%0b expected 0/0", res_cls, res_sign));
    chk(res_exp == '0 && res_mant == '0 && res_sticky == 1'b0,
        $sformatf("R1 exp/mant/sticky: got %h/%h/%0b expected 0", res_exp, res_mant, res_sticky));

    ma = mk_mant(11); mb = mk_mant(23); mc = mk_mant(37);
    // R7 one times one, sparse multiplier words (R9)
    issue(1'b0, 3'd1, 16'd3, ONE, 1'b1, 3'd1, 16'hfffb, ONE, "R7 R9 one*one");
    // R7 dense operands
    issue(1'b1, 3'd1, 16'd100, ma, 1'b1, 3'd1, 16'd7, mb, "R7 dense");
    // R8 product near four
    issue(1'b0, 3'd1, 16'd0, ALL1, 1'b0, 3'd1, 16'd0, ALL1, "R8 renorm");
    // R9 middle words zero, low word nonzero
    issue(1'b0, 3'd1, 16'd1, mc, 1'b0, 3'd1, 16'd2, ONE | MANT_W'(32'h8000_0010), "R9 skip middle");
    // R9 low word zero, middle words dense
    issue(1'b1, 3'd1, 16'd5, ma, 1'b0, 3'd1, 16'd9, mb & ~MANT_W'(32'hffff_ffff), "R9 skip low");
    // R10 guard bits in multiplier ignored
    issue(1'b0, 3'd1, 16'd4, mc, 1'b0, 3'd1, 16'd4, ONE | MANT_W'(3), "R10 guard ignored");
    issue(1'b0, 3'd1, 16'd4, mc, 1'b0, 3'd1, 16'd4, mb | MANT_W'(3), "R10 guard dense");
    // R7 exponent wraps
    issue(1'b0, 3'd1, 16'h7fff, mb, 1'b1, 3'd1, 16'h0001, ma, "R7 exp wrap");
    // R11 start while busy is ignored
    issue(1'b0, 3'd1, 16'd8, ma, 1'b0, 3'd1, 16'd8, mc, "R11 busy poke base");
    a_cls = 3'd2; b_cls = 3'd0; start = 1'b1;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    // specials; each is issued in the done cycle of the previous item (R12)
    issue(1'b1, 3'd3, 16'd12, ma, 1'b0, 3'd1, 16'd3, mb, "R2 R3 R12 nan swapped");
    issue(1'b0, 3'd4, 16'd21, mb, 1'b1, 3'd3, 16'd22, mc, "R2 R3 snan over qnan");
    issue(1'b1, 3'd3, 16'd31, ma, 1'b1, 3'd4, 16'd32, mc, "R2 R3 snan in b");
    issue(1'b1, 3'd2, 16'd40, ONE, 1'b0, 3'd0, 16'd41, '0, "R4 R6 inf*zero");
    issue(1'b0, 3'd0, 16'd42, '0, 1'b1, 3'd2, 16'd43, ONE, "R4 zero*inf");
    issue(1'b1, 3'd2, 16'd44, mb, 1'b0, 3'd1, 16'd45, ma, "R4 inf*num");
    issue(1'b1, 3'd2, 16'd46, ma, 1'b1, 3'd2, 16'd47, mc, "R4 inf*inf");
    issue(1'b0, 3'd1, 16'd50, ma, 1'b1, 3'd0, 16'd51, MANT_W'(5), "R5 num*zero");
    issue(1'b1, 3'd0, 16'd52, MANT_W'(9), 1'b1, 3'd0, 16'd53, MANT_W'(6), "R5 zero*zero");
    issue(1'b0, 3'd1, 16'd2, mb, 1'b1, 3'd1, 16'd3, ma, "R12 number after special");
    while (busy || sbq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(sbq.size() == 0 && !busy, $sformatf("R11 drain: got %0d pending, expected 0", sbq.size()));
    summary();
  end

endmodule